// File: doc/BRIEF.md
# Prescaled Match/Capture Timer

This block is a 32-bit timer for a peripheral clock domain. A programmable prescaler divides the clock. The divided ticks advance a timer count. Four compare channels watch the count. When a channel matches, it can raise a flag, restart the count, halt counting, or drive one of four output pins. Two input channels take a snapshot of the count when a chosen edge arrives on an asynchronous pin.

Software reaches all state through a flat word-addressed register bus. The bus has an address, write data, a write strobe and combinational read data. The bus is always ready, so it has no back-pressure and no valid/ready handshake: every strobed write takes effect at the next clock edge. A single interrupt line reports pending flags. Flags are cleared by writing ones. A bus write takes precedence over a hardware update of the same register in the same cycle, with one exception: a flag raised by an event in the same cycle as its clear stays set.

Register offsets (byte addresses, 32-bit words):

| Offset | Register |
|---|---|
| 0x00 | flags |
| 0x04 | control |
| 0x08 | count |
| 0x0C | prescale limit |
| 0x10 | prescale count |
| 0x14 | match actions |
| 0x18 + 4n | compare value n |
| 0x28 | capture control |
| 0x2C + 4c | snapshot c |
| 0x3C | pin control |

Top module: `ptimer_top`

## Requirements
- R1: While control bit 0 is 1 and control bit 1 is 0, the prescale count steps 0,1,…,L, where L is the prescale limit. On the cycle it equals L (a "tick"), it returns to 0 and the count advances by one. So the count moves once every L+1 clocks. Without a tick, the count changes only through a bus write or the hold bit.
- R2: While control bit 1 is 1, the count and the prescale count are forced to 0 at every edge, overriding bus writes to either of them.
- R3: The flags register holds match flags in bits 0–3 and snapshot flags in bits 4–5. Writing a 1 to a bit clears it and writing a 0 leaves it unchanged. A flag is only set by its event.
- R4: A channel matches on a tick at which the count equals its compare value. Match-action bit 3n set makes a match of channel n set flag n.
- R5: Match-action bit 3n+1 set makes a match of channel n load 0 into the count instead of incrementing it, giving a period of compare+1 ticks.
- R6: Match-action bit 3n+2 set makes a match of channel n clear control bit 0. The count then holds its value unless a restart also applies.
- R7: Pin control bits [3:0] drive the match pins directly and are read and writable. Bits [5+2n:4+2n] select what a match of channel n does to pin n: 00 leaves it, 01 drives low, 10 drives high, 11 inverts.
- R8: Capture control bits 3c and 3c+2 enable capture on a rising and on a falling edge of capture pin c. The pin passes through two synchronizer flops before edge detection. A detected edge copies the count into snapshot c.
- R9: Capture control bit 3c+1 set makes a snapshot on channel c set flag 4+c. When it is clear, the flag is unaffected.
- R10: The interrupt output is 1 exactly when any flag is set.
- R11: The count and prescale count can be written directly. Writing the prescale limit also returns the prescale count to 0.
- R12: Registers sit at the offsets in the table above. Compare values and snapshots read back as full 32-bit words. Control, flags, match-action, capture control and pin control read back with their unused upper bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cap_in | input | 2 | Asynchronous capture pins |
| irq | output | 1 | Interrupt request, OR of all flags |
| match_out | output | 4 | External match pins |

## Verification
The assertions check invariants that must hold on every cycle:
- the hold bit zeroes the count (R2);
- the count stays still between ticks and writes (R1);
- flags never drop without a write (R3);
- the pins move only on ticks or pin-control writes (R7);
- snapshots change only on capture events (R8).

The action selections themselves can only be shown by the bench's scenarios. These are the exact restart period, the frozen value after a stop, the pin action codes, the synchronizer latency and edge polarity of captures, and the per-channel interrupt enables. The bench drives those scenarios against a behavioural model that is compared on every clock.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_FLAG  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h04;
  localparam logic [ADDR_W-1:0] A_CNT   = 8'h08;
  localparam logic [ADDR_W-1:0] A_PLIM  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_PCNT  = 8'h10;
  localparam logic [ADDR_W-1:0] A_MACT  = 8'h14;
  localparam logic [ADDR_W-1:0] A_CMP0  = 8'h18;
  localparam logic [ADDR_W-1:0] A_CAPC  = 8'h28;
  localparam logic [ADDR_W-1:0] A_SNAP0 = 8'h2C;
  localparam logic [ADDR_W-1:0] A_PINC  = 8'h3C;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'b00,
    PIN_LOW  = 2'b01,
    PIN_HIGH = 2'b10,
    PIN_INV  = 2'b11
  } pin_act_e;

  function automatic logic pin_apply(pin_act_e act, logic cur);
    case (act)
      PIN_LOW:  return 1'b0;
      PIN_HIGH: return 1'b1;
      PIN_INV:  return ~cur;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         hold,
  input  logic [W-1:0] limit,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         restart,
  output logic         tick,
  output logic [W-1:0] pcnt
);
  logic [W-1:0] pcnt_q;

  assign tick = run && !hold && (pcnt_q == limit);
  assign pcnt = pcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (hold)    pcnt_q <= '0;
    else if (load)    pcnt_q <= load_val;
    else if (restart) pcnt_q <= '0;
    else if (tick)    pcnt_q <= '0;
    else if (run)     pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_match_ch.sv
module ptmr_match_ch
  import ptmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic [2:0]   act,
  input  logic [1:0]   pin_sel,
  input  logic         pin_cur,
  output logic         hit_flag,
  output logic         hit_zero,
  output logic         hit_halt,
  output logic         pin_nxt
);
  logic hit;

  assign hit      = tick && (cnt == cmp);
  assign hit_flag = hit && act[0];
  assign hit_zero = hit && act[1];
  assign hit_halt = hit && act[2];
  assign pin_nxt  = hit ? pin_apply(pin_act_e'(pin_sel), pin_cur) : pin_cur;
endmodule

// File: rtl/ptmr_cap_ch.sv
module ptmr_cap_ch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin,
  input  logic         rise_en,
  input  logic         fall_en,
  input  logic [W-1:0] cnt,
  output logic         evt,
  output logic [W-1:0] snap
);
  logic sync_a, sync_b, prev;
  logic [W-1:0] snap_q;

  assign evt  = (rise_en && sync_b && !prev) || (fall_en && !sync_b && prev);
  assign snap = snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      prev   <= 1'b0;
      snap_q <= '0;
    end else begin
      sync_a <= pin;
      sync_b <= sync_a;
      prev   <= sync_b;
      if (evt) snap_q <= cnt;
    end
  end
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
  import ptmr_pkg::*;
#(
  parameter int TW     = 32,
  parameter int NMATCH = 4,
  parameter int NCAP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic [NCAP-1:0]   cap_in,
  output logic              irq,
  output logic [NMATCH-1:0] match_out
);
  localparam int NFLAG = NMATCH + NCAP;
  localparam int MACTW = 3 * NMATCH;
  localparam int CAPCW = 3 * NCAP;
  localparam int PINCW = 3 * NMATCH;

  logic [1:0]       ctrl_q;
  logic [TW-1:0]    cnt_q, plim_q, pcnt;
  logic [MACTW-1:0] mact_q;
  logic [CAPCW-1:0] capc_q;
  logic [PINCW-1:0] pinc_q;
  logic [NFLAG-1:0] flag_q, flag_set;
  logic [TW-1:0]    cmp_q [NMATCH];
  logic [NCAP*TW-1:0] snap_flat;
  logic [NMATCH-1:0] hit_flag, hit_zero, hit_halt, pin_nxt, wr_cmp;
  logic [NCAP-1:0]   cap_evt;
  logic tick;
  logic wr_flag, wr_ctrl, wr_cnt, wr_plim, wr_pcnt, wr_mact, wr_capc, wr_pinc;

  assign wr_flag = bus_we && bus_addr == A_FLAG;
  assign wr_ctrl = bus_we && bus_addr == A_CTRL;
  assign wr_cnt  = bus_we && bus_addr == A_CNT;
  assign wr_plim = bus_we && bus_addr == A_PLIM;
  assign wr_pcnt = bus_we && bus_addr == A_PCNT;
  assign wr_mact = bus_we && bus_addr == A_MACT;
  assign wr_capc = bus_we && bus_addr == A_CAPC;
  assign wr_pinc = bus_we && bus_addr == A_PINC;

  ptmr_prescale #(.W(TW)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[0]), .hold(ctrl_q[1]),
    .limit(plim_q), .load(wr_pcnt), .load_val(bus_wdata[TW-1:0]),
    .restart(wr_plim), .tick(tick), .pcnt(pcnt)
  );

  for (genvar n = 0; n < NMATCH; n++) begin : g_match
    assign wr_cmp[n] = bus_we && bus_addr == A_CMP0 + ADDR_W'(4 * n);
    ptmr_match_ch #(.W(TW)) u_ch (
      .tick(tick), .cnt(cnt_q), .cmp(cmp_q[n]),
      .act(mact_q[3*n +: 3]), .pin_sel(pinc_q[NMATCH + 2*n +: 2]),
      .pin_cur(pinc_q[n]), .hit_flag(hit_flag[n]), .hit_zero(hit_zero[n]),
      .hit_halt(hit_halt[n]), .pin_nxt(pin_nxt[n])
    );
    always_ff @(posedge clk) begin
      if (!rst_n)         cmp_q[n] <= '0;
      else if (wr_cmp[n]) cmp_q[n] <= bus_wdata[TW-1:0];
    end
    assign flag_set[n] = hit_flag[n];
  end

  for (genvar c = 0; c < NCAP; c++) begin : g_cap
    ptmr_cap_ch #(.W(TW)) u_cap (
      .clk(clk), .rst_n(rst_n), .pin(cap_in[c]),
      .rise_en(capc_q[3*c]), .fall_en(capc_q[3*c + 2]), .cnt(cnt_q),
      .evt(cap_evt[c]), .snap(snap_flat[c*TW +: TW])
    );
    assign flag_set[NMATCH + c] = cap_evt[c] && capc_q[3*c + 1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      plim_q <= '0;
      mact_q <= '0;
      capc_q <= '0;
      pinc_q <= '0;
      flag_q <= '0;
    end else begin
      if (wr_ctrl)         ctrl_q <= bus_wdata[1:0];
      else if (|hit_halt)  ctrl_q[0] <= 1'b0;

      if (ctrl_q[1])       cnt_q <= '0;
      else if (wr_cnt)     cnt_q <= bus_wdata[TW-1:0];
      else if (tick) begin
        if (|hit_zero)       cnt_q <= '0;
        else if (!(|hit_halt)) cnt_q <= cnt_q + 1'b1;
      end

      if (wr_plim) plim_q <= bus_wdata[TW-1:0];
      if (wr_mact) mact_q <= bus_wdata[MACTW-1:0];
      if (wr_capc) capc_q <= bus_wdata[CAPCW-1:0];

      if (wr_pinc) pinc_q <= bus_wdata[PINCW-1:0];
      else         pinc_q[NMATCH-1:0] <= pin_nxt;

      flag_q <= (flag_q & ~(wr_flag ? bus_wdata[NFLAG-1:0] : '0)) | flag_set;
    end
  end

  assign irq       = |flag_q;
  assign match_out = pinc_q[NMATCH-1:0];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_FLAG: bus_rdata[NFLAG-1:0] = flag_q;
      A_CTRL: bus_rdata[1:0]       = ctrl_q;
      A_CNT:  bus_rdata[TW-1:0]    = cnt_q;
      A_PLIM: bus_rdata[TW-1:0]    = plim_q;
      A_PCNT: bus_rdata[TW-1:0]    = pcnt;
      A_MACT: bus_rdata[MACTW-1:0] = mact_q;
      A_CAPC: bus_rdata[CAPCW-1:0] = capc_q;
      A_PINC: bus_rdata[PINCW-1:0] = pinc_q;
      default: begin
        for (int n = 0; n < NMATCH; n++)
          if (bus_addr == A_CMP0 + ADDR_W'(4 * n)) bus_rdata[TW-1:0] = cmp_q[n];
        for (int c = 0; c < NCAP; c++)
          if (bus_addr == A_SNAP0 + ADDR_W'(4 * c)) bus_rdata[TW-1:0] = snap_flat[c*TW +: TW];
      end
    endcase
  end
endmodule

// File: rtl/ptimer_chk.sv
module ptimer_chk #(
  parameter int TW     = 32,
  parameter int NCAP   = 2,
  parameter int NFLAG  = 6,
  parameter int NMATCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [TW-1:0]     cnt,
  input logic              hold,
  input logic              cnt_wr,
  input logic [NFLAG-1:0]  flags,
  input logic              flag_wr,
  input logic [NMATCH-1:0] pins,
  input logic              pinc_wr,
  input logic [NCAP-1:0]   cap_evt,
  input logic [NCAP*TW-1:0] snaps
);
  assert_hold_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0));

  assert_cnt_still_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr && !hold) |=> $stable(cnt));

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flags & $past(flags)) == $past(flags)));

  assert_pin_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !pinc_wr) |=> $stable(pins));

  assert_snap_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt == '0) |=> $stable(snaps));
endmodule

bind ptimer_top ptimer_chk #(.TW(TW), .NCAP(NCAP), .NFLAG(NFLAG), .NMATCH(NMATCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt_q), .hold(ctrl_q[1]),
  .cnt_wr(wr_cnt), .flags(flag_q), .flag_wr(wr_flag), .pins(match_out),
  .pinc_wr(wr_pinc), .cap_evt(cap_evt), .snaps(snap_flat)
);

// File: tb/sim_ptimer_top.sv
module sim_ptimer_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h08;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [1:0]  cap_in = '0;
  logic        irq;
  logic [3:0]  match_out;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  ptimer_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .cap_in(cap_in), .irq(irq),
    .match_out(match_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [1:0]  m_ctrl;
  logic [31:0] m_cnt, m_pcnt, m_plim;
  logic [11:0] m_mact, m_pinc;
  logic [5:0]  m_capc, m_flag;
  logic [31:0] m_cmp [4];
  logic [31:0] m_snap [2];
  logic [1:0]  m_s1, m_s2, m_pv;

  function automatic logic [31:0] mread(logic [7:0] a);
    case (a)
      8'h00: return {26'd0, m_flag};
      8'h04: return {30'd0, m_ctrl};
      8'h08: return m_cnt;
      8'h0C: return m_plim;
      8'h10: return m_pcnt;
      8'h14: return {20'd0, m_mact};
      8'h18: return m_cmp[0];
      8'h1C: return m_cmp[1];
      8'h20: return m_cmp[2];
      8'h24: return m_cmp[3];
      8'h28: return {26'd0, m_capc};
      8'h2C: return m_snap[0];
      8'h30: return m_snap[1];
      8'h3C: return {20'd0, m_pinc};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_pcnt = 0; m_plim = 0; m_mact = 0; m_pinc = 0;
      m_capc = 0; m_flag = 0; m_s1 = 0; m_s2 = 0; m_pv = 0;
      for (int i = 0; i < 4; i++) m_cmp[i] = 0;
      for (int i = 0; i < 2; i++) m_snap[i] = 0;
    end else begin
      bit tk, zero, halt, wr;
      logic [5:0]  setf;
      logic [3:0]  npins;
      logic [31:0] ncnt, npcnt;
      wr = bus_we;
      tk = m_ctrl[0] && !m_ctrl[1] && (m_pcnt == m_plim);
      zero = 0; halt = 0; setf = 0; npins = m_pinc[3:0];
      for (int n = 0; n < 4; n++) begin
        if (tk && m_cnt == m_cmp[n]) begin
          if (m_mact[3*n])   setf[n] = 1;
          if (m_mact[3*n+1]) zero = 1;
          if (m_mact[3*n+2]) halt = 1;
          case (m_pinc[4+2*n +: 2])
            2'b01: npins[n] = 1'b0;
            2'b10: npins[n] = 1'b1;
            2'b11: npins[n] = ~npins[n];
            default: ;
          endcase
        end
      end
      if (m_ctrl[1]) ncnt = 0;
      else if (wr && bus_addr == 8'h08) ncnt = bus_wdata;
      else if (tk) ncnt = zero ? 32'd0 : (halt ? m_cnt : m_cnt + 1);
      else ncnt = m_cnt;
      if (m_ctrl[1]) npcnt = 0;
      else if (wr && bus_addr == 8'h10) npcnt = bus_wdata;
      else if (wr && bus_addr == 8'h0C) npcnt = 0;
      else if (tk) npcnt = 0;
      else if (m_ctrl[0]) npcnt = m_pcnt + 1;
      else npcnt = m_pcnt;
      for (int c = 0; c < 2; c++) begin
        if ((m_s2[c] && !m_pv[c] && m_capc[3*c]) || (!m_s2[c] && m_pv[c] && m_capc[3*c+2])) begin
          m_snap[c] = m_cnt;
          if (m_capc[3*c+1]) setf[4+c] = 1;
        end
      end
      m_pv = m_s2; m_s2 = m_s1; m_s1 = cap_in;
      if (wr && bus_addr == 8'h04) m_ctrl = bus_wdata[1:0];
      else if (halt) m_ctrl[0] = 1'b0;
      m_flag = (m_flag & ~((wr && bus_addr == 8'h00) ? bus_wdata[5:0] : 6'd0)) | setf;
      if (wr && bus_addr == 8'h3C) m_pinc = bus_wdata[11:0];
      else m_pinc[3:0] = npins;
      if (wr && bus_addr == 8'h0C) m_plim = bus_wdata;
      if (wr && bus_addr == 8'h14) m_mact = bus_wdata[11:0];
      if (wr && bus_addr == 8'h28) m_capc = bus_wdata[5:0];
      for (int n = 0; n < 4; n++)
        if (wr && bus_addr == 8'h18 + 8'(4*n)) m_cmp[n] = bus_wdata;
      m_cnt = ncnt; m_pcnt = npcnt;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string addr_tag(logic [7:0] a);
    case (a)
      8'h00: return "R3";
      8'h04: return "R6";
      8'h08: return "R1";
      8'h10: return "R11";
      8'h2C, 8'h30: return "R8";
      8'h3C: return "R7";
      default: return "R12";
    endcase
  endfunction

  // per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(addr_tag(bus_addr), bus_rdata, mread(bus_addr));
      chk("R10", {31'd0, irq}, {31'd0, m_flag != 0});
      chk("R7", {28'd0, match_out}, {28'd0, m_pinc[3:0]});
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h08;
  endtask

  task automatic peek(logic [7:0] a, string tag, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #2;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state (R12, R10, R7)
    peek(8'h08, "R12 count after reset", 0);
    peek(8'h00, "R3 flags after reset", 0);
    chk("R10 irq after reset", {31'd0, irq}, 0);
    chk("R7 pins after reset", {28'd0, match_out}, 0);

    // R1: limit 2 -> one step every 3 clocks
    wr(8'h0C, 2);
    wr(8'h04, 1);
    idle(9);
    peek(8'h08, "R1 count after 10 clocks", 3);

    // R2: hold bit forces zero and beats a count write
    wr(8'h04, 3);
    wr(8'h08, 77);
    peek(8'h08, "R2 count while held", 0);
    peek(8'h10, "R2 prescale while held", 0);

    // R4/R5: restart on compare 4, limit 0 -> period 5
    wr(8'h04, 2);
    wr(8'h0C, 0);
    wr(8'h18, 4);
    wr(8'h14, 12'h003);
    wr(8'h00, 6'h3F);
    wr(8'h04, 1);
    idle(4);
    peek(8'h00, "R4 flag0 after match", 32'h1);
    peek(8'h08, "R5 count restarted", 1);
    idle(20);

    // R3: write-zero has no effect, write-one clears
    wr(8'h04, 0);
    wr(8'h00, 0);
    peek(8'h00, "R3 write zero keeps flag", 32'h1);
    chk("R10 irq with flag", {31'd0, irq}, 1);
    wr(8'h00, 1);
    peek(8'h00, "R3 write one clears", 0);
    chk("R10 irq cleared", {31'd0, irq}, 0);

    // R6: stop on channel 1 at 3
    wr(8'h04, 2);
    wr(8'h14, 12'h020);
    wr(8'h1C, 3);
    wr(8'h04, 1);
    idle(10);
    peek(8'h04, "R6 enable cleared", 0);
    peek(8'h08, "R6 count frozen", 3);

    // R7: ch0 drive high at 1, ch2 invert + restart at 2
    wr(8'h04, 2);
    wr(8'h14, 12'h080);
    wr(8'h18, 1);
    wr(8'h20, 2);
    wr(8'h3C, 12'h320);
    wr(8'h04, 1);
    idle(3);
    peek(8'h3C, "R7 pin actions applied", 32'h325);
    idle(12);
    wr(8'h3C, 12'h00A);
    chk("R7 direct pin write", {28'd0, match_out}, 4'hA);

    // R8/R9: ch0 rising with flag, ch1 falling without flag
    wr(8'h04, 2);
    wr(8'h14, 0);
    wr(8'h3C, 0);
    wr(8'h00, 6'h3F);
    wr(8'h28, 6'h23);
    wr(8'h04, 1);
    idle(5);
    @(negedge clk); cap_in = 2'b10;
    idle(8);
    peek(8'h2C, "R8 rising snapshot", m_snap[0]);
    peek(8'h30, "R8 ch1 rising ignored", 0);
    @(negedge clk); cap_in = 2'b01;
    idle(8);
    peek(8'h30, "R8 falling snapshot", m_snap[1]);
    chk("R8 falling snapshot nonzero", {31'd0, m_snap[1] != 0}, 1);
    peek(8'h00, "R9 only ch0 flag", 32'h10);

    // R11: direct writes and limit write restarting prescale count
    wr(8'h04, 0);
    wr(8'h08, 10);
    wr(8'h10, 5);
    peek(8'h08, "R11 count write", 10);
    peek(8'h10, "R11 prescale write", 5);
    wr(8'h0C, 7);
    peek(8'h10, "R11 limit write restarts", 0);

    // R12: full-width compare readback
    wr(8'h24, 32'hDEADBEEF);
    peek(8'h24, "R12 compare 3 readback", 32'hDEADBEEF);

    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule